// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block turns a requested PLL output frequency, given in kHz, into the four integer divider settings of a PLL fed by a 24 MHz reference. The settings are the reference divider, the feedback divider, and the first and second post-dividers. It picks the post-dividers first, so that the VCO lands in its legal window. It then sweeps the reference divider and, for each value, rounds the feedback divider to the nearest integer. The candidate that gives the smallest VCO error is kept.

A request is issued with a one-cycle `start` while the engine is idle. `busy` stays high while the search runs. `done` pulses for one cycle when the results are posted, and `err` reports whether a usable setting was found. Every division uses one shared multi-cycle restoring divider. The results stay on the outputs until the next request completes.

Top module: `pll_div_search`

## Requirements
- R1: A request with `target_khz` equal to 0 is rejected. `done` and `err` are high in the cycle that follows the edge that samples `start`.
- R2: The first post-divider starts as ceil(800000 / target). If that value exceeds 7, the second post-divider is ceil(value / 7) and the first becomes ceil(value / second). Otherwise the second post-divider is 1.
- R3: The VCO is target × postdiv1 × postdiv2. The request fails with `err` if the second post-divider exceeds 7, or if the VCO lies outside 800000 to 3200000 kHz (both limits inclusive).
- R4: The reference divider takes the values 1, 2, … up to 62. For each value the reference step is floor(24000 / refdiv) and the feedback divider is floor(vco / step). A candidate whose feedback divider is at least 3200 or at most 16 is skipped.
- R5: Let the remainder be vco − fbdiv × step. When the remainder exceeds floor(step / 2) and fbdiv + 1 is below 3200, the feedback divider is raised by one and the error becomes step − remainder. Otherwise the error is the remainder.
- R6: A candidate replaces the kept one only when its error is strictly smaller, so on a tie the lowest reference divider wins. The sweep stops as soon as the kept error is 0.
- R7: The kept error starts equal to the VCO. The search succeeds only if the final kept error is at most 4000 kHz, and on success `dev_khz` reports that error.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` is high, and it is low in that cycle. `done` lasts one cycle. A `start` that arrives while busy is ignored. The result outputs change only in the cycle in which `done` rises.
- R9: When `err` is reported, `refdiv`, `fbdiv`, `postdiv1`, `postdiv2` and `dev_khz` are all 0.
- R10: After reset, `busy`, `done`, `err` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| target_khz | input | W | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No usable setting for the last request |
| refdiv | output | RDW | Chosen reference divider |
| fbdiv | output | FBW | Chosen feedback divider |
| postdiv1 | output | PDW | Chosen first post-divider |
| postdiv2 | output | PDW | Chosen second post-divider |
| dev_khz | output | W | VCO error of the chosen setting in kHz |

## Verification
The bench builds the engine with a 24-bit datapath. That is wide enough for every legal VCO value, and it shortens each quotient to 24 divider steps, so a complete 62-step reference sweep costs only a few thousand cycles. With that setting, several dozen targets can be run through the whole search and compared with an arithmetic model of the selection rules. The targets cover exact hits that stop early, cases that need rounding up, both post-divider paths, and rejection at both ends of the VCO window and at zero. Handshake timing, ignored restarts and output holding are checked on the same runs.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_PD1,
        PS_PD2,
        PS_PD3,
        PS_VCO,
        PS_FREF,
        PS_FB,
        PS_FIN
    } pll_state_e;

endpackage

// File: rtl/pll_seq_div.sv
// Restoring divider: one quotient bit per cycle, W cycles per division.
module pll_seq_div #(
    parameter int W = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  r;
        logic [W-1:0]  q;
        logic [W-1:0]  d;
    } dv_t;

    dv_t cur_q, nxt_d;

    logic [W:0]   trial;
    logic [W-1:0] diff;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        trial      = {cur_q.r, cur_q.q[W-1]};
        diff       = trial[W-1:0] - cur_q.d;
        if (go) begin
            nxt_d.busy = 1'b1;
            nxt_d.cnt  = CW'(W);
            nxt_d.r    = '0;
            nxt_d.q    = dividend;
            nxt_d.d    = divisor;
        end else if (cur_q.busy) begin
            if (trial >= {1'b0, cur_q.d}) begin
                nxt_d.r = diff;
                nxt_d.q = {cur_q.q[W-2:0], 1'b1};
            end else begin
                nxt_d.r = trial[W-1:0];
                nxt_d.q = {cur_q.q[W-2:0], 1'b0};
            end
            nxt_d.cnt = cur_q.cnt - CW'(1);
            if (cur_q.cnt == CW'(1)) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign done = cur_q.done;
    assign quot = cur_q.q;
    assign rem  = cur_q.r;

endmodule

// File: rtl/pll_cand_eval.sv
// Rounds one feedback candidate to the nearest integer and compares its error.
module pll_cand_eval #(
    parameter int W      = 32,
    parameter int FB_MIN = 16,
    parameter int FB_MAX = 3200,
    localparam int FBW   = $clog2(FB_MAX)
) (
    input  logic [W-1:0]   fb_raw,
    input  logic [W-1:0]   rem,
    input  logic [W-1:0]   fref,
    input  logic [W-1:0]   best,
    output logic [FBW-1:0] fb_sel,
    output logic [W-1:0]   cand_err,
    output logic           better
);

    localparam logic [W-1:0] K_FB_MIN = W'(FB_MIN);
    localparam logic [W-1:0] K_FB_MAX = W'(FB_MAX);

    logic         in_win;
    logic         round_up;
    logic [W-1:0] fb_inc;

    always_comb begin
        fb_inc   = fb_raw + W'(1);
        in_win   = (fb_raw < K_FB_MAX) && (fb_raw > K_FB_MIN);
        round_up = (rem > (fref >> 1)) && (fb_inc < K_FB_MAX);
        if (round_up) begin
            fb_sel   = fb_inc[FBW-1:0];
            cand_err = fref - rem;
        end else begin
            fb_sel   = fb_raw[FBW-1:0];
            cand_err = rem;
        end
        better = in_win && (cand_err < best);
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int W             = 32,
    parameter int REF_KHZ       = 24000,
    parameter int VCO_MIN_KHZ   = 800000,
    parameter int VCO_MAX_KHZ   = 3200000,
    parameter int FB_MIN        = 16,
    parameter int FB_MAX        = 3200,
    parameter int REFDIV_LIMIT  = 63,
    parameter int PD_MAX        = 7,
    parameter int ERR_LIMIT_KHZ = 4000,
    localparam int RDW          = $clog2(REFDIV_LIMIT),
    localparam int FBW          = $clog2(FB_MAX),
    localparam int PDW          = $clog2(PD_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   target_khz,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic [RDW-1:0] refdiv,
    output logic [FBW-1:0] fbdiv,
    output logic [PDW-1:0] postdiv1,
    output logic [PDW-1:0] postdiv2,
    output logic [W-1:0]   dev_khz
);

    localparam int PW = W + 2 * PDW;
    localparam logic [W-1:0]  K_REF     = W'(REF_KHZ);
    localparam logic [W-1:0]  K_PD_MAX  = W'(PD_MAX);
    localparam logic [W-1:0]  K_ERR_LIM = W'(ERR_LIMIT_KHZ);
    localparam logic [W-1:0]  K_RD_LIM  = W'(REFDIV_LIMIT);
    localparam logic [PW-1:0] K_VCO_MIN = PW'(VCO_MIN_KHZ);
    localparam logic [PW-1:0] K_VCO_MAX = PW'(VCO_MAX_KHZ);

    typedef struct packed {
        pll_state_e     st;
        logic           busy;
        logic           done;
        logic           err;
        logic           fail;
        logic           go;
        logic [W-1:0]   a;
        logic [W-1:0]   b;
        logic [W-1:0]   tgt;
        logic [W-1:0]   raw;
        logic [W-1:0]   vco;
        logic [W-1:0]   fref;
        logic [W-1:0]   best;
        logic [PDW-1:0] p1;
        logic [PDW-1:0] p2;
        logic [RDW-1:0] rd;
        logic [RDW-1:0] best_rd;
        logic [FBW-1:0] best_fb;
        logic [RDW-1:0] o_rd;
        logic [FBW-1:0] o_fb;
        logic [PDW-1:0] o_p1;
        logic [PDW-1:0] o_p2;
        logic [W-1:0]   o_dev;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic           div_done;
    logic [W-1:0]   div_quot;
    logic [W-1:0]   div_rem;
    logic [W-1:0]   q_ceil;
    logic [PW-1:0]  prod;
    logic [FBW-1:0] cand_fb;
    logic [W-1:0]   cand_err;
    logic           cand_better;
    logic [W-1:0]   best_after;
    logic [W-1:0]   rd_next;

    pll_seq_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (cur_q.go),
        .dividend (cur_q.a),
        .divisor  (cur_q.b),
        .done     (div_done),
        .quot     (div_quot),
        .rem      (div_rem)
    );

    pll_cand_eval #(.W(W), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX)) u_eval (
        .fb_raw   (div_quot),
        .rem      (div_rem),
        .fref     (cur_q.fref),
        .best     (cur_q.best),
        .fb_sel   (cand_fb),
        .cand_err (cand_err),
        .better   (cand_better)
    );

    always_comb begin
        q_ceil     = div_quot + W'(div_rem != '0);
        prod       = PW'(cur_q.tgt) * PW'(cur_q.p1) * PW'(cur_q.p2);
        best_after = cand_better ? cand_err : cur_q.best;
        rd_next    = W'(cur_q.rd) + W'(1);

        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.go   = 1'b0;

        unique case (cur_q.st)
            PS_IDLE: begin
                if (start) begin
                    if (target_khz == '0) begin
                        nxt_d.done  = 1'b1;
                        nxt_d.err   = 1'b1;
                        nxt_d.o_rd  = '0;
                        nxt_d.o_fb  = '0;
                        nxt_d.o_p1  = '0;
                        nxt_d.o_p2  = '0;
                        nxt_d.o_dev = '0;
                    end else begin
                        nxt_d.busy = 1'b1;
                        nxt_d.fail = 1'b0;
                        nxt_d.tgt  = target_khz;
                        nxt_d.go   = 1'b1;
                        nxt_d.a    = W'(VCO_MIN_KHZ);
                        nxt_d.b    = target_khz;
                        nxt_d.st   = PS_PD1;
                    end
                end
            end
            PS_PD1: begin
                if (div_done) begin
                    if (q_ceil > K_PD_MAX) begin
                        nxt_d.raw = q_ceil;
                        nxt_d.go  = 1'b1;
                        nxt_d.a   = q_ceil;
                        nxt_d.b   = K_PD_MAX;
                        nxt_d.st  = PS_PD2;
                    end else begin
                        nxt_d.p1 = q_ceil[PDW-1:0];
                        nxt_d.p2 = PDW'(1);
                        nxt_d.st = PS_VCO;
                    end
                end
            end
            PS_PD2: begin
                if (div_done) begin
                    if (q_ceil > K_PD_MAX) begin
                        nxt_d.fail = 1'b1;
                        nxt_d.st   = PS_FIN;
                    end else begin
                        nxt_d.p2 = q_ceil[PDW-1:0];
                        nxt_d.go = 1'b1;
                        nxt_d.a  = cur_q.raw;
                        nxt_d.b  = q_ceil;
                        nxt_d.st = PS_PD3;
                    end
                end
            end
            PS_PD3: begin
                if (div_done) begin
                    nxt_d.p1 = q_ceil[PDW-1:0];
                    nxt_d.st = PS_VCO;
                end
            end
            PS_VCO: begin
                if (prod < K_VCO_MIN || prod > K_VCO_MAX) begin
                    nxt_d.fail = 1'b1;
                    nxt_d.st   = PS_FIN;
                end else begin
                    nxt_d.vco     = prod[W-1:0];
                    nxt_d.best    = prod[W-1:0];
                    nxt_d.best_rd = '0;
                    nxt_d.best_fb = '0;
                    nxt_d.rd      = RDW'(1);
                    nxt_d.go      = 1'b1;
                    nxt_d.a       = K_REF;
                    nxt_d.b       = W'(1);
                    nxt_d.st      = PS_FREF;
                end
            end
            PS_FREF: begin
                if (div_done) begin
                    nxt_d.fref = div_quot;
                    nxt_d.go   = 1'b1;
                    nxt_d.a    = cur_q.vco;
                    nxt_d.b    = div_quot;
                    nxt_d.st   = PS_FB;
                end
            end
            PS_FB: begin
                if (div_done) begin
                    if (cand_better) begin
                        nxt_d.best    = cand_err;
                        nxt_d.best_rd = cur_q.rd;
                        nxt_d.best_fb = cand_fb;
                    end
                    if (rd_next < K_RD_LIM && best_after != '0) begin
                        nxt_d.rd = rd_next[RDW-1:0];
                        nxt_d.go = 1'b1;
                        nxt_d.a  = K_REF;
                        nxt_d.b  = rd_next;
                        nxt_d.st = PS_FREF;
                    end else begin
                        nxt_d.st = PS_FIN;
                    end
                end
            end
            PS_FIN: begin
                nxt_d.done = 1'b1;
                nxt_d.busy = 1'b0;
                nxt_d.st   = PS_IDLE;
                if (cur_q.fail || cur_q.best > K_ERR_LIM) begin
                    nxt_d.err   = 1'b1;
                    nxt_d.o_rd  = '0;
                    nxt_d.o_fb  = '0;
                    nxt_d.o_p1  = '0;
                    nxt_d.o_p2  = '0;
                    nxt_d.o_dev = '0;
                end else begin
                    nxt_d.err   = 1'b0;
                    nxt_d.o_rd  = cur_q.best_rd;
                    nxt_d.o_fb  = cur_q.best_fb;
                    nxt_d.o_p1  = cur_q.p1;
                    nxt_d.o_p2  = cur_q.p2;
                    nxt_d.o_dev = cur_q.best;
                end
            end
            default: nxt_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy     = cur_q.busy;
    assign done     = cur_q.done;
    assign err      = cur_q.err;
    assign refdiv   = cur_q.o_rd;
    assign fbdiv    = cur_q.o_fb;
    assign postdiv1 = cur_q.o_p1;
    assign postdiv2 = cur_q.o_p2;
    assign dev_khz  = cur_q.o_dev;

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int W             = 32,
    parameter int FB_MIN        = 16,
    parameter int FB_MAX        = 3200,
    parameter int REFDIV_LIMIT  = 63,
    parameter int PD_MAX        = 7,
    parameter int ERR_LIMIT_KHZ = 4000,
    parameter int RDW           = 6,
    parameter int FBW           = 12,
    parameter int PDW           = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   target_khz,
    input logic           busy,
    input logic           done,
    input logic           err,
    input logic [RDW-1:0] refdiv,
    input logic [FBW-1:0] fbdiv,
    input logic [PDW-1:0] postdiv1,
    input logic [PDW-1:0] postdiv2,
    input logic [W-1:0]   dev_khz
);

    assert_zero_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && target_khz == '0) |=> (done && err));

    assert_pd_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (postdiv1 >= PDW'(1) && postdiv1 <= PDW'(PD_MAX)
                            && postdiv2 >= PDW'(1) && postdiv2 <= PDW'(PD_MAX)));

    assert_fb_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (fbdiv > FBW'(FB_MIN) && fbdiv < FBW'(FB_MAX)
                            && refdiv >= RDW'(1) && refdiv < RDW'(REFDIV_LIMIT)));

    assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (dev_khz <= W'(ERR_LIMIT_KHZ)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(refdiv) && $stable(fbdiv) && $stable(postdiv1)
                   && $stable(postdiv2) && $stable(dev_khz) && $stable(err)));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (refdiv == '0 && fbdiv == '0 && postdiv1 == '0
                           && postdiv2 == '0 && dev_khz == '0));

endmodule

bind pll_div_search pll_div_search_chk #(
    .W             (W),
    .FB_MIN        (FB_MIN),
    .FB_MAX        (FB_MAX),
    .REFDIV_LIMIT  (REFDIV_LIMIT),
    .PD_MAX        (PD_MAX),
    .ERR_LIMIT_KHZ (ERR_LIMIT_KHZ),
    .RDW           (RDW),
    .FBW           (FBW),
    .PDW           (PDW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .target_khz (target_khz),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .refdiv     (refdiv),
    .fbdiv      (fbdiv),
    .postdiv1   (postdiv1),
    .postdiv2   (postdiv2),
    .dev_khz    (dev_khz)
);

// File: tb/pll_div_search_tb_top.sv
module pll_div_search_tb_top;

    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  target_khz = '0;
    logic          busy, done, err;
    logic [5:0]    refdiv;
    logic [11:0]   fbdiv;
    logic [2:0]    postdiv1, postdiv2;
    logic [W-1:0]  dev_khz;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pll_div_search #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .busy(busy), .done(done), .err(err), .refdiv(refdiv), .fbdiv(fbdiv),
        .postdiv1(postdiv1), .postdiv2(postdiv2), .dev_khz(dev_khz)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Arithmetic model of the selection rules.
    task automatic model(input longint t, output bit e, output longint rd,
                         output longint fb, output longint p1, output longint p2,
                         output longint dv);
        longint vco, best, fr, f, d;
        e = 0; rd = 0; fb = 0; p1 = 0; p2 = 0; dv = 0;
        if (t == 0) begin e = 1; return; end
        p1 = (800000 + t - 1) / t;
        p2 = 1;
        if (p1 > 7) begin
            p2 = (p1 + 6) / 7;
            p1 = (p1 + p2 - 1) / p2;
        end
        vco = t * p1 * p2;
        if (vco < 800000 || vco > 3200000 || p2 > 7) begin
            e = 1; rd = 0; fb = 0; p1 = 0; p2 = 0; return;
        end
        best = vco;
        for (int r = 1; r < 63 && best != 0; r++) begin
            fr = 24000 / r;
            f  = vco / fr;
            if (f >= 3200 || f <= 16) continue;
            d = vco - f * fr;
            if (f + 1 < 3200 && d > fr / 2) begin
                f++;
                d = fr - d;
            end
            if (d >= best) continue;
            best = d; rd = r; fb = f;
        end
        if (best > 4000) begin
            e = 1; rd = 0; fb = 0; p1 = 0; p2 = 0; return;
        end
        dv = best;
    endtask

    task automatic run(input longint t, input bit inject, output int lat);
        bit e; longint rd, fb, p1, p2, dv;
        int busy_bad = 0;
        logic [5:0] h_rd; logic [11:0] h_fb; logic [W-1:0] h_dev;
        model(t, e, rd, fb, p1, p2, dv);
        @(negedge clk);
        start = 1'b1;
        target_khz = W'(t);
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (inject && lat == 4) begin
                start = 1'b1;
                target_khz = W'(t + 12345);
            end
            if (!done && !busy) busy_bad++;
        end while (!done && lat < 20000);
        start = 1'b0;
        check(done == 1'b1, "R8", "done seen", done, 1);
        check(busy_bad == 0, "R8", "busy while searching", busy_bad, 0);
        check(busy == 1'b0, "R8", "busy low with done", busy, 0);
        check(err == e, e ? "R3,R7" : "R7", "err", err, e);
        check(postdiv1 == p1 && postdiv2 == p2, "R2", "postdiv pair",
              {postdiv1, postdiv2}, (p1 << 3) | p2);
        check(refdiv == rd, "R4,R6", "refdiv", refdiv, rd);
        check(fbdiv == fb, "R4,R5", "fbdiv", fbdiv, fb);
        check(dev_khz == dv, "R7", "deviation", dev_khz, dv);
        if (e) check(refdiv == 0 && fbdiv == 0 && postdiv1 == 0 && postdiv2 == 0
                     && dev_khz == 0, "R9", "zeroed settings on err",
                     {refdiv, fbdiv}, 0);
        h_rd = refdiv; h_fb = fbdiv; h_dev = dev_khz;
        @(negedge clk);
        check(done == 1'b0, "R8", "done single cycle", done, 0);
        repeat (3) @(negedge clk);
        check(refdiv == h_rd && fbdiv == h_fb && dev_khz == h_dev, "R8",
              "results held", dev_khz, h_dev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lat;
        longint tl [30] = '{16000, 25000, 27000, 33333, 48000, 74250, 100000,
                            114286, 148500, 200000, 297000, 333333, 400000,
                            594000, 799999, 800000, 1000000, 1234567, 1600000,
                            2000000, 3199999, 3200000, 3200001, 5000000, 100,
                            1, 13586, 40744, 67902, 95060};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(busy == 0 && done == 0 && err == 0, "R10", "flags after reset",
              {busy, done, err}, 0);
        check(refdiv == 0 && fbdiv == 0 && postdiv1 == 0 && postdiv2 == 0
              && dev_khz == 0, "R10", "results after reset", dev_khz, 0);

        // R1: zero target rejected at once
        run(0, 1'b0, lat);
        check(lat == 1, "R1", "zero-target latency", lat, 1);

        // R6: exact hit at refdiv 1 stops the sweep early
        run(600000, 1'b0, lat);
        check(lat < 8 * W, "R6", "early stop latency", lat, 8 * W);

        // R8: a second start while busy is ignored
        run(1000000, 1'b1, lat);

        foreach (tl[i]) run(tl[i], 1'b0, lat);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule